// File: doc/BRIEF.md
# Motor Lock Detection Timer

This block decides whether a brushless motor has stalled and, once it has, throttles the power stage into a slow intermittent pattern. Stalling is judged from the Hall sensors. The block counts system clocks since the last Hall edge. If that count reaches a speed limit before the next edge arrives, the rotor is treated as locked. The limit depends on direction. When the rotor turns the commanded way, the limit corresponds to about 1 Hz. When it turns against the command, the limit corresponds to about 5 Hz.

Once the rotor is locked, the drive-enable output follows a repeating pattern. It stays high for a set number of ticks from a slow external timing oscillator, then low for six times as many ticks. Detection is armed by a speed-command flag that signals the run threshold. It is disarmed by a second flag that signals the off threshold. Between the two thresholds the block keeps whatever state it had. Two flags report the state of the external timing pin. An open pin forces the drive off at once. A grounded pin turns lock detection off and leaves the drive on.

Top module: `mlock_guard`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `drive_en` is 1, the block is disarmed and no lock is held.
- R2: Lock detection is armed on the clock edge that sees `cmd_run`=1. It is disarmed on the edge that sees `cmd_off`=1, which wins if both flags are 1. With both flags at 0 the armed state holds. While disarmed, `drive_en` stays 1 however long the Hall inputs stay quiet.
- R3: With `dir_match`=1 the limit is SLOW_MATCH_CYC clocks. Suppose Hall edges arrive every g clocks after arming. The block locks when g > SLOW_MATCH_CYC and never locks when g <= SLOW_MATCH_CYC.
- R4: With `dir_match`=0 the same rule applies with the limit SLOW_OPPOSE_CYC.
- R5: Once locked, `drive_en` is 1 for DRIVE_TICKS `osc_tick` pulses, then 0 for STOP_TICKS pulses, and the cycle repeats. `drive_en` changes on the edge that takes the last pulse of each phase. Pulses that arrive before the lock do not count.
- R6: A Hall edge that comes before the count reaches the current limit clears the lock. `drive_en` is 1 after that edge, and the next lock starts again with a full drive phase. A Hall edge that comes at or beyond the limit leaves the lock in place.
- R7: `cmd_off`=1 clears the lock and the counters, so `drive_en` is 1 after that edge. After re-arming, the period count and the drive phase start again from zero.
- R8: `tpin_open`=1 forces `drive_en` to 0 in the same cycle, without waiting for a clock. It also clears the lock and the counters, and it takes precedence over `tpin_gnd`.
- R9: `tpin_gnd`=1, with `tpin_open`=0, holds `drive_en` at 1 and keeps lock detection cleared. Counting restarts from zero once the flag drops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| osc_tick | input | 1 | One-clock pulse per period of the slow timing oscillator |
| hall_edge | input | 1 | One-clock strobe on any Hall commutation edge |
| dir_match | input | 1 | 1 when the rotation matches the commanded direction |
| cmd_run | input | 1 | Speed command is above the run threshold |
| cmd_off | input | 1 | Speed command is at or below the off threshold |
| tpin_open | input | 1 | The timing pin is detected open |
| tpin_gnd | input | 1 | The timing pin is tied to ground |
| drive_en | output | 1 | Permission for the power stage to drive |

## Verification
The bench sweeps the Hall edge spacing g from 2 clocks to a few clocks past each limit, in both directions, with oscillator pulses running alongside. A design that compares the count off by one would lock at g equal to the limit, or fail to lock at one past it. A design that mixes up the two limits would fail the sweep in one direction. Directed runs count exact drive and stop lengths and the pulses ignored before a lock. A timer that kept running while unlocked would drop `drive_en` early. A design that kept its counters across `cmd_off`, an open pin or a grounded pin would lock again at once after re-arming. The bench also checks that a lone slow edge keeps the lock while a quick second edge releases it. A design that released on any edge, or on none, fails that check.

// File: rtl/mlock_pkg.sv
package mlock_pkg;

    typedef enum logic {
        PH_DRIVE = 1'b0,
        PH_STOP  = 1'b1
    } mlock_phase_e;

    // Per-cycle control decisions of the lock state machine
    typedef struct packed {
        logic hold_clr;  // detector held in its initial state
        logic lock_set;  // period limit reached this cycle
        logic lock_clr;  // quick Hall edge seen this cycle
    } mlock_ctl_t;

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Bits needed to hold values 0..n
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/mlock_arm.sv
module mlock_arm (
    input  logic clk,
    input  logic rst,
    input  logic cmd_run,
    input  logic cmd_off,
    output logic armed_q
);
    // Two-threshold hysteresis: off dominates, neither holds
    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
        end else if (cmd_off) begin
            armed_q <= 1'b0;
        end else if (cmd_run) begin
            armed_q <= 1'b1;
        end
    end
endmodule

// File: rtl/mlock_period_meter.sv
module mlock_period_meter
    import mlock_pkg::*;
#(
    parameter int unsigned SLOW_MATCH_CYC  = 5000000,
    parameter int unsigned SLOW_OPPOSE_CYC = 1000000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic hall_edge,
    input  logic dir_match,
    output logic slow_reached,
    output logic edge_fast
);
    localparam int unsigned SAT = umax(SLOW_MATCH_CYC, SLOW_OPPOSE_CYC);
    localparam int unsigned W   = cnt_width(SAT);

    logic [W-1:0] per_cnt_q;
    logic [W-1:0] limit;

    // Limit picked by the current direction relation
    always_comb begin
        limit = dir_match ? W'(SLOW_MATCH_CYC) : W'(SLOW_OPPOSE_CYC);
    end

    // Clocks since last Hall edge, saturating at the larger limit
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            per_cnt_q <= '0;
        end else if (hall_edge) begin
            per_cnt_q <= '0;
        end else if (per_cnt_q != W'(SAT)) begin
            per_cnt_q <= per_cnt_q + 1'b1;
        end
    end

    always_comb begin
        slow_reached = (per_cnt_q >= limit);
        edge_fast    = hall_edge && !slow_reached;
    end
endmodule

// File: rtl/mlock_cycle_timer.sv
module mlock_cycle_timer
    import mlock_pkg::*;
#(
    parameter  int unsigned DRIVE_TICKS = 500,
    parameter  int unsigned STOP_TICKS  = 3000,
    localparam int unsigned TW          = cnt_width(umax(DRIVE_TICKS, STOP_TICKS) - 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              osc_tick,
    output mlock_phase_e      phase_q,
    output logic [TW-1:0]     tick_q
);
    logic [TW-1:0] phase_last;
    logic          at_end;

    always_comb begin
        phase_last = (phase_q == PH_DRIVE) ? TW'(DRIVE_TICKS - 1) : TW'(STOP_TICKS - 1);
        at_end     = (tick_q == phase_last);
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            phase_q <= PH_DRIVE;
            tick_q  <= '0;
        end else if (osc_tick) begin
            if (at_end) begin
                phase_q <= (phase_q == PH_DRIVE) ? PH_STOP : PH_DRIVE;
                tick_q  <= '0;
            end else begin
                tick_q  <= tick_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/mlock_guard.sv
module mlock_guard
    import mlock_pkg::*;
#(
    parameter  int unsigned SLOW_MATCH_CYC  = 5000000,
    parameter  int unsigned SLOW_OPPOSE_CYC = 1000000,
    parameter  int unsigned DRIVE_TICKS     = 500,
    parameter  int unsigned STOP_TICKS      = 3000,
    localparam int unsigned TW              = cnt_width(umax(DRIVE_TICKS, STOP_TICKS) - 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic osc_tick,
    input  logic hall_edge,
    input  logic dir_match,
    input  logic cmd_run,
    input  logic cmd_off,
    input  logic tpin_open,
    input  logic tpin_gnd,
    output logic drive_en
);
    logic          armed_q;
    logic          lock_q;
    logic          slow_reached;
    logic          edge_fast;
    logic          timer_run;
    mlock_phase_e  phase_q;
    logic [TW-1:0] tick_cnt;
    mlock_ctl_t    ctl;

    mlock_arm u_arm (
        .clk     (clk),
        .rst     (rst),
        .cmd_run (cmd_run),
        .cmd_off (cmd_off),
        .armed_q (armed_q)
    );

    always_comb begin
        ctl.hold_clr = !armed_q || cmd_off || tpin_open || tpin_gnd;
        ctl.lock_clr = edge_fast;
        ctl.lock_set = slow_reached;
        timer_run    = lock_q && !ctl.hold_clr && !ctl.lock_clr;
    end

    mlock_period_meter #(
        .SLOW_MATCH_CYC  (SLOW_MATCH_CYC),
        .SLOW_OPPOSE_CYC (SLOW_OPPOSE_CYC)
    ) u_meter (
        .clk          (clk),
        .rst          (rst),
        .clr          (ctl.hold_clr),
        .hall_edge    (hall_edge),
        .dir_match    (dir_match),
        .slow_reached (slow_reached),
        .edge_fast    (edge_fast)
    );

    // Lock state: a quick edge wins over the limit test
    always_ff @(posedge clk) begin
        if (rst || ctl.hold_clr) begin
            lock_q <= 1'b0;
        end else if (ctl.lock_clr) begin
            lock_q <= 1'b0;
        end else if (ctl.lock_set) begin
            lock_q <= 1'b1;
        end
    end

    mlock_cycle_timer #(
        .DRIVE_TICKS (DRIVE_TICKS),
        .STOP_TICKS  (STOP_TICKS)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .run      (timer_run),
        .osc_tick (osc_tick),
        .phase_q  (phase_q),
        .tick_q   (tick_cnt)
    );

    // Pin flags act without a clock; open pin has top priority
    always_comb begin
        if (tpin_open) begin
            drive_en = 1'b0;
        end else if (tpin_gnd) begin
            drive_en = 1'b1;
        end else begin
            drive_en = !(lock_q && (phase_q == PH_STOP));
        end
    end
endmodule

// File: rtl/mlock_guard_chk.sv
module mlock_guard_chk
    import mlock_pkg::*;
#(
    parameter int unsigned DRIVE_TICKS = 500,
    parameter int unsigned STOP_TICKS  = 3000,
    parameter int unsigned TW          = 12
) (
    input logic          clk,
    input logic          rst,
    input logic          osc_tick,
    input logic          cmd_off,
    input logic          tpin_open,
    input logic          tpin_gnd,
    input logic          drive_en,
    input logic          armed_q,
    input logic          lock_q,
    input logic          edge_fast,
    input mlock_phase_e  phase_q,
    input logic [TW-1:0] tick_cnt
);
    a_r8_open_forces_off: assert property (@(posedge clk) disable iff (rst)
        tpin_open |-> !drive_en);

    a_r9_gnd_keeps_on: assert property (@(posedge clk) disable iff (rst)
        (tpin_gnd && !tpin_open) |-> drive_en);

    a_r7_off_releases: assert property (@(posedge clk) disable iff (rst)
        (cmd_off && !tpin_open) |=> (drive_en || tpin_open));

    a_r2_lock_needs_arm: assert property (@(posedge clk) disable iff (rst)
        lock_q |-> armed_q);

    a_r6_quick_edge_unlocks: assert property (@(posedge clk) disable iff (rst)
        (lock_q && edge_fast) |=> !lock_q);

    a_r5_drop_on_tick: assert property (@(posedge clk) disable iff (rst)
        $fell(drive_en) |-> ($past(osc_tick) || tpin_open || $past(tpin_gnd)));

    a_r5_tick_in_range: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_DRIVE) ? (tick_cnt < TW'(DRIVE_TICKS)) : (tick_cnt < TW'(STOP_TICKS)));
endmodule

bind mlock_guard mlock_guard_chk #(
    .DRIVE_TICKS (DRIVE_TICKS),
    .STOP_TICKS  (STOP_TICKS),
    .TW          (TW)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .osc_tick  (osc_tick),
    .cmd_off   (cmd_off),
    .tpin_open (tpin_open),
    .tpin_gnd  (tpin_gnd),
    .drive_en  (drive_en),
    .armed_q   (armed_q),
    .lock_q    (lock_q),
    .edge_fast (edge_fast),
    .phase_q   (phase_q),
    .tick_cnt  (tick_cnt)
);

// File: tb/mlock_guard_tb_top.sv
module mlock_guard_tb_top;
    localparam int unsigned LIM_M = 40;
    localparam int unsigned LIM_O = 8;
    localparam int unsigned DRV   = 3;
    localparam int unsigned STP   = 18;

    logic clk = 1'b0;
    logic rst, osc_tick, hall_edge, dir_match, cmd_run, cmd_off, tpin_open, tpin_gnd;
    logic drive_en;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    mlock_guard #(
        .SLOW_MATCH_CYC  (LIM_M),
        .SLOW_OPPOSE_CYC (LIM_O),
        .DRIVE_TICKS     (DRV),
        .STOP_TICKS      (STP)
    ) dut_i (
        .clk       (clk),
        .rst       (rst),
        .osc_tick  (osc_tick),
        .hall_edge (hall_edge),
        .dir_match (dir_match),
        .cmd_run   (cmd_run),
        .cmd_off   (cmd_off),
        .tpin_open (tpin_open),
        .tpin_gnd  (tpin_gnd),
        .drive_en  (drive_en)
    );

    task automatic step(input int n);
        repeat (n) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic tick(input int n);
        repeat (n) begin
            osc_tick = 1'b1;
            step(1);
            osc_tick = 1'b0;
        end
    endtask

    task automatic hall_pulse();
        hall_edge = 1'b1;
        step(1);
        hall_edge = 1'b0;
    endtask

    task automatic arm();
        cmd_off = 1'b1;
        step(1);
        cmd_off = 1'b0;
        cmd_run = 1'b1;
        step(1);
        cmd_run = 1'b0;
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; osc_tick = 1'b0; hall_edge = 1'b0; dir_match = 1'b1;
        cmd_run = 1'b0; cmd_off = 1'b0; tpin_open = 1'b0; tpin_gnd = 1'b0;
        step(3);
        chk("R1", "drive_en during reset", drive_en, 1);
        rst = 1'b0;
        step(1);
        chk("R1", "drive_en after reset", drive_en, 1);

        // R2: never armed, long quiet Hall, ticks running
        step(60);
        tick(25);
        chk("R2", "unarmed stays enabled", drive_en, 1);

        // R3/R5: lock with matching direction, pulses before lock ignored
        arm();
        tick(5);
        step(40);
        tick(2);
        chk("R5", "drive after 2 of 3 ticks", drive_en, 1);
        tick(1);
        chk("R5", "stop after 3 drive ticks", drive_en, 0);
        tick(STP - 1);
        chk("R5", "still stopped at 17 ticks", drive_en, 0);
        tick(1);
        chk("R5", "drive after 18 stop ticks", drive_en, 1);
        tick(DRV);
        chk("R5", "second cycle stops", drive_en, 0);

        // R6: slow edge keeps lock, quick edge clears it
        hall_pulse();
        chk("R6", "slow edge keeps lock", drive_en, 0);
        step(4);
        hall_pulse();
        chk("R6", "quick edge releases", drive_en, 1);
        step(45);
        tick(DRV - 1);
        chk("R6", "relock starts full drive", drive_en, 1);
        tick(1);
        chk("R6", "relock then stops", drive_en, 0);

        // R7: off threshold clears and disarms
        cmd_off = 1'b1;
        step(1);
        cmd_off = 1'b0;
        chk("R7", "off releases drive", drive_en, 1);
        step(60);
        tick(25);
        chk("R7", "stays disarmed", drive_en, 1);
        cmd_run = 1'b1; cmd_off = 1'b1;
        step(1);
        cmd_run = 1'b0; cmd_off = 1'b0;
        step(60);
        tick(5);
        chk("R2", "off wins over run", drive_en, 1);
        cmd_run = 1'b1;
        step(1);
        cmd_run = 1'b0;
        tick(DRV);
        chk("R7", "rearm restarts count", drive_en, 1);
        step(40);
        tick(DRV);
        chk("R7", "rearm locks after limit", drive_en, 0);

        // R4 versus R3 with a 9-clock quiet window
        dir_match = 1'b0;
        arm();
        step(9);
        tick(DRV);
        chk("R4", "opposing limit locks at 9", drive_en, 0);
        dir_match = 1'b1;
        arm();
        step(9);
        tick(DRV);
        chk("R3", "matching limit not reached", drive_en, 1);

        // R8: open pin
        arm();
        step(41);
        tpin_open = 1'b1;
        #1;
        chk("R8", "open forces off at once", drive_en, 0);
        step(3);
        chk("R8", "open holds off", drive_en, 0);
        tpin_open = 1'b0;
        #1;
        chk("R8", "release restores drive", drive_en, 1);
        tick(DRV);
        chk("R8", "lock cleared by open", drive_en, 1);

        // R9: grounded pin
        arm();
        tpin_gnd = 1'b1;
        step(60);
        tick(25);
        chk("R9", "grounded keeps drive", drive_en, 1);
        tpin_open = 1'b1;
        #1;
        chk("R8", "open beats grounded", drive_en, 0);
        tpin_open = 1'b0;
        tpin_gnd  = 1'b0;
        #1;
        tick(DRV);
        chk("R9", "count restarts after ground", drive_en, 1);

        // R3/R4 sweep of Hall spacing around each limit
        for (int d = 0; d < 2; d++) begin
            int lim;
            lim = (d == 1) ? LIM_M : LIM_O;
            dir_match = (d == 1);
            for (int g = 2; g <= lim + 4; g++) begin
                bit went_low;
                arm();
                went_low = 0;
                for (int c = 0; c < 200; c++) begin
                    hall_edge = ((c % g) == 0);
                    osc_tick  = ((c % 2) == 1);
                    step(1);
                    if (!drive_en) went_low = 1;
                end
                hall_edge = 1'b0;
                osc_tick  = 1'b0;
                chk((d == 1) ? "R3" : "R4", $sformatf("spacing %0d locks", g),
                    int'(went_low), (g > lim) ? 1 : 0);
            end
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule